// File: doc/BRIEF.md
# Almost-Flag Offset Register Loader

This block fills the two threshold registers that a FIFO's almost-empty and almost-full comparators use. The load method is fixed by three configuration pins sampled while the synchronous master reset is high. One of three fixed presets can be loaded straight away. The first two words on the FIFO write port can be taken as offsets instead of data. The offsets can also be shifted in one bit at a time on a serial input.

During write-port programming, the `wr_divert` output tells the surrounding FIFO that the current write belongs to the offset registers and must not reach memory. `prog_done` tells it that normal writes may begin. A partial reset of the FIFO leaves the offsets and the programming progress as they are. While it is active, no programming step is accepted.

Top module: `offset_loader`

## Requirements
- R1: With `cfg_spm`=1 and `cfg_fs`=2'b11 at master reset, both offsets read 64. `prog_done` is 1 and `wr_divert` is 0, already while reset is held and from then on.
- R2: With `cfg_spm`=1, `cfg_fs`=2'b10 loads 16 into both offsets, and `cfg_fs`=2'b01 loads 8 into both. In both cases `prog_done` is 1 at once.
- R3: With `cfg_spm`=1 and `cfg_fs`=2'b00, write-port programming is selected. The offsets read 0, `prog_done` is 0 and `wr_divert` is 1 until two writes have been taken.
- R4: In write-port programming, the first accepted write loads `ofs_full` and the second loads `ofs_empty`. Each takes `wr_data[OFS_W-1:0]`, with bit OFS_W-1 as the MSB, and ignores the upper bits. After the second write, `prog_done` is 1 and `wr_divert` is 0, both visible one cycle after the write.
- R5: Once `prog_done` is 1, further writes and serial bits leave both offsets unchanged.
- R6: With `cfg_spm`=0, 2×OFS_W serial bits are taken MSB first, `ofs_full` before `ofs_empty`. Both offsets stay 0 and `prog_done` stays 0 until the last bit, then both update with `prog_done` one cycle later.
- R7: `ser_din` is ignored in any cycle where `ser_en` is 0.
- R8: While `part_rst` is 1, no write or serial bit is accepted, and the offsets and `prog_done` are kept.
- R9: Changing the configuration pins after master reset release has no effect until the next master reset.
- R10: A new master reset restarts selection. Offsets that are not preset return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| part_rst | input | 1 | Partial reset; blocks programming steps, keeps state |
| cfg_spm | input | 1 | Method pin: 1 selects preset or write-port programming, 0 selects serial |
| cfg_fs | input | 2 | Preset select: 11→64, 10→16, 01→8, 00→write-port programming |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | DATA_W | FIFO write data |
| ser_en | input | 1 | Serial bit qualifier |
| ser_din | input | 1 | Serial offset data, MSB first |
| ofs_empty | output | OFS_W | Almost-empty offset |
| ofs_full | output | OFS_W | Almost-full offset |
| prog_done | output | 1 | Both offsets loaded; normal writes allowed |
| wr_divert | output | 1 | Current write goes to the offset registers, not memory |

## Verification
Partial reset can coincide with a programming step. The bench asserts `part_rst` in the same cycle as the first pending write in write-port mode, and again in the same cycle as the final serial bit. It then expects the offsets, `prog_done` and `wr_divert` to be unchanged at the next sample. Repeating the same step with `part_rst` low must then complete the load, which shows that the step was blocked and not lost.

// File: rtl/olr_pkg.sv
package olr_pkg;

  typedef enum logic [1:0] {
    LM_SERIAL   = 2'd0,
    LM_PARALLEL = 2'd1,
    LM_PRESET   = 2'd2
  } load_mode_e;

  function automatic load_mode_e decode_mode(input logic spm, input logic [1:0] fs);
    if (!spm)           return LM_SERIAL;
    else if (fs == 2'b00) return LM_PARALLEL;
    else                return LM_PRESET;
  endfunction

  function automatic int unsigned preset_value(input logic [1:0] fs);
    case (fs)
      2'b11:   return 64;
      2'b10:   return 16;
      2'b01:   return 8;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/olr_mode_capture.sv
module olr_mode_capture
  import olr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_spm,
  input  logic [1:0] cfg_fs,
  output load_mode_e mode_q
);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= decode_mode(cfg_spm, cfg_fs);
  end

  // R9: method is frozen between master resets
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q));

endmodule

// File: rtl/olr_par_path.sv
module olr_par_path #(
  parameter int OFS_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              busy,
  input  logic              part_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ld_y,
  output logic              ld_x,
  output logic [OFS_W-1:0]  ld_val
);

  logic phase;
  logic take;

  assign take   = sel && busy && wr_en && !part_rst;
  assign ld_y   = take && !phase;
  assign ld_x   = take && phase;
  assign ld_val = wr_data[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)       phase <= 1'b0;
    else if (take) phase <= 1'b1;
  end

  // R8: partial reset freezes write-port progress
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (rst)
    part_rst |=> $stable(phase));

  // R4: the second load can only follow the first
  a_r4_order: assert property (@(posedge clk) disable iff (rst)
    ld_x |-> $past(phase) || $past(ld_y));

endmodule

// File: rtl/olr_ser_path.sv
module olr_ser_path #(
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             busy,
  input  logic             part_rst,
  input  logic             ser_en,
  input  logic             ser_din,
  output logic             ld,
  output logic [OFS_W-1:0] ld_y,
  output logic [OFS_W-1:0] ld_x
);

  localparam int TOT = 2 * OFS_W;
  localparam int CW  = $clog2(TOT + 1);

  logic [CW-1:0]  cnt;
  logic [TOT-1:0] sreg;
  logic [TOT-1:0] nxt;
  logic           take;

  assign take = sel && busy && ser_en && !part_rst;
  assign nxt  = {sreg[TOT-2:0], ser_din};
  assign ld   = take && (cnt == CW'(TOT - 1));
  assign ld_y = nxt[TOT-1:OFS_W];
  assign ld_x = nxt[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sreg <= '0;
    end else if (take) begin
      sreg <= nxt;
      cnt  <= ld ? '0 : cnt + 1'b1;
    end
  end

  // R6: bit counter never passes the frame length
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(TOT));

  // R7: no shift without the qualifier
  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    !ser_en |=> $stable(sreg));

endmodule

// File: rtl/offset_loader.sv
module offset_loader
  import olr_pkg::*;
#(
  parameter int OFS_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              part_rst,
  input  logic              cfg_spm,
  input  logic [1:0]        cfg_fs,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ser_en,
  input  logic              ser_din,
  output logic [OFS_W-1:0]  ofs_empty,
  output logic [OFS_W-1:0]  ofs_full,
  output logic              prog_done,
  output logic              wr_divert
);

  load_mode_e       mode_q;
  load_mode_e       mode_live;
  logic             p_ld_y, p_ld_x, s_ld;
  logic [OFS_W-1:0] p_val, s_y, s_x;

  assign mode_live = decode_mode(cfg_spm, cfg_fs);

  olr_mode_capture u_mode (
    .clk(clk), .rst(rst), .cfg_spm(cfg_spm), .cfg_fs(cfg_fs), .mode_q(mode_q)
  );

  olr_par_path #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_par (
    .clk(clk), .rst(rst), .sel(mode_q == LM_PARALLEL), .busy(!prog_done),
    .part_rst(part_rst), .wr_en(wr_en), .wr_data(wr_data),
    .ld_y(p_ld_y), .ld_x(p_ld_x), .ld_val(p_val)
  );

  olr_ser_path #(.OFS_W(OFS_W)) u_ser (
    .clk(clk), .rst(rst), .sel(mode_q == LM_SERIAL), .busy(!prog_done),
    .part_rst(part_rst), .ser_en(ser_en), .ser_din(ser_din),
    .ld(s_ld), .ld_y(s_y), .ld_x(s_x)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_empty <= OFS_W'(preset_value(cfg_fs) * (mode_live == LM_PRESET));
      ofs_full  <= OFS_W'(preset_value(cfg_fs) * (mode_live == LM_PRESET));
      prog_done <= (mode_live == LM_PRESET);
      wr_divert <= (mode_live == LM_PARALLEL);
    end else begin
      if (p_ld_y) ofs_full <= p_val;
      if (p_ld_x) begin
        ofs_empty <= p_val;
        prog_done <= 1'b1;
        wr_divert <= 1'b0;
      end
      if (s_ld) begin
        ofs_full  <= s_y;
        ofs_empty <= s_x;
        prog_done <= 1'b1;
      end
    end
  end

  // R5: completion is sticky until master reset
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> prog_done);

  // R5: offsets frozen after completion
  a_r5_ofs_frozen: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> $stable(ofs_empty) && $stable(ofs_full));

  // R3: divert and completion never together
  a_r3_divert_excl: assert property (@(posedge clk) disable iff (rst)
    !(wr_divert && prog_done));

  // R8: partial reset keeps all loader outputs
  a_r8_part_hold: assert property (@(posedge clk) disable iff (rst)
    part_rst |=> $stable(ofs_empty) && $stable(ofs_full) && $stable(prog_done));

endmodule

// File: tb/sim_offset_loader.sv
module sim_offset_loader;

  localparam int OFS_W  = 12;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              part_rst = 1'b0;
  logic              cfg_spm = 1'b1;
  logic [1:0]        cfg_fs = 2'b11;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              ser_en = 1'b0;
  logic              ser_din = 1'b0;
  logic [OFS_W-1:0]  ofs_empty, ofs_full;
  logic              prog_done, wr_divert;

  always #2 clk = ~clk;

  offset_loader #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .part_rst(part_rst), .cfg_spm(cfg_spm), .cfg_fs(cfg_fs),
    .wr_en(wr_en), .wr_data(wr_data), .ser_en(ser_en), .ser_din(ser_din),
    .ofs_empty(ofs_empty), .ofs_full(ofs_full), .prog_done(prog_done),
    .wr_divert(wr_divert)
  );

  typedef struct {
    logic [OFS_W-1:0] x;
    logic [OFS_W-1:0] y;
    logic             done;
    logic             div;
    string            tag;
  } item_t;

  item_t q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  // scoreboard monitor: compares one cycle-phase after each negedge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (ofs_empty !== it.x || ofs_full !== it.y ||
          prog_done !== it.done || wr_divert !== it.div) begin
        n_fail++;
        $display("FAIL %s: got x=%h y=%h done=%b div=%b, expected x=%h y=%h done=%b div=%b",
                 it.tag, ofs_empty, ofs_full, prog_done, wr_divert,
                 it.x, it.y, it.done, it.div);
      end
    end
  end

  task automatic expect_st(input logic [OFS_W-1:0] x, input logic [OFS_W-1:0] y,
                           input logic done, input logic div, input string tag);
    item_t it;
    it.x = x; it.y = y; it.done = done; it.div = div; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic mreset(input logic spm, input logic [1:0] fs);
    @(negedge clk);
    rst = 1'b1; cfg_spm = spm; cfg_fs = fs;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    cfg_spm = ~spm; cfg_fs = ~fs;   // R9: pins move after release
  endtask

  task automatic wr(input logic [DATA_W-1:0] d, input logic pr);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; part_rst = pr;
    @(negedge clk);
    wr_en = 1'b0; part_rst = 1'b0;
  endtask

  task automatic sbit(input logic en, input logic b, input logic pr);
    @(negedge clk);
    ser_en = en; ser_din = b; part_rst = pr;
    @(negedge clk);
    ser_en = 1'b0; ser_din = ~b; part_rst = 1'b0;
  endtask

  initial begin
    logic [2*OFS_W-1:0] frame;
    frame = {12'h5A3, 12'h9C6};

    // R1: preset 64, also visible during reset
    @(negedge clk); @(negedge clk);
    expect_st(12'd64, 12'd64, 1'b1, 1'b0, "R1 in reset");
    mreset(1'b1, 2'b11);
    expect_st(12'd64, 12'd64, 1'b1, 1'b0, "R1");
    wr(16'h0123, 1'b0);
    expect_st(12'd64, 12'd64, 1'b1, 1'b0, "R5 write after preset");

    // R2: other presets
    mreset(1'b1, 2'b10);
    expect_st(12'd16, 12'd16, 1'b1, 1'b0, "R2 sel 10");
    mreset(1'b1, 2'b01);
    expect_st(12'd8, 12'd8, 1'b1, 1'b0, "R2 sel 01");

    // R3/R4: write-port programming, pins flipped to serial-preset after release
    mreset(1'b1, 2'b00);
    expect_st(12'd0, 12'd0, 1'b0, 1'b1, "R3 R10");
    repeat (3) @(negedge clk);
    expect_st(12'd0, 12'd0, 1'b0, 1'b1, "R9 pins changed");
    wr(16'hFABC, 1'b1);
    expect_st(12'd0, 12'd0, 1'b0, 1'b1, "R8 write with part_rst");
    wr(16'hFABC, 1'b0);
    expect_st(12'd0, 12'hABC, 1'b0, 1'b1, "R4 first write Y");
    wr(16'h1123, 1'b0);
    expect_st(12'h123, 12'hABC, 1'b1, 1'b0, "R4 second write X");
    wr(16'h0777, 1'b0);
    expect_st(12'h123, 12'hABC, 1'b1, 1'b0, "R5 write after done");
    @(negedge clk); part_rst = 1'b1;
    @(negedge clk); part_rst = 1'b0;
    expect_st(12'h123, 12'hABC, 1'b1, 1'b0, "R8 partial reset keeps offsets");

    // R6/R7: serial programming
    mreset(1'b0, 2'b00);
    expect_st(12'd0, 12'd0, 1'b0, 1'b0, "R6 R10 serial start");
    for (int i = 0; i < 2*OFS_W - 1; i++) begin
      sbit(1'b1, frame[2*OFS_W-1-i], 1'b0);
      if (i == 5) begin
        sbit(1'b0, 1'b1, 1'b0);
        sbit(1'b0, 1'b0, 1'b0);
        expect_st(12'd0, 12'd0, 1'b0, 1'b0, "R7 idle bits");
      end
    end
    expect_st(12'd0, 12'd0, 1'b0, 1'b0, "R6 incomplete frame");
    sbit(1'b1, frame[0], 1'b1);
    expect_st(12'd0, 12'd0, 1'b0, 1'b0, "R8 last bit with part_rst");
    sbit(1'b1, frame[0], 1'b0);
    expect_st(12'h9C6, 12'h5A3, 1'b1, 1'b0, "R6 R7 frame loaded");
    for (int i = 0; i < 4; i++) sbit(1'b1, 1'b1, 1'b0);
    expect_st(12'h9C6, 12'h5A3, 1'b1, 1'b0, "R5 bits after done");

    // R10: new reset from done state
    mreset(1'b1, 2'b00);
    expect_st(12'd0, 12'd0, 1'b0, 1'b1, "R10 restart");

    repeat (3) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule